// File: doc/BRIEF.md
# Registered Output Cell Bank with Preload Lock

This block models a bank of registered output cells as found at the outputs of a small sum-of-products logic device. Each cell holds one D flip-flop. On a clock edge the flip-flop takes the cell's sum term. Shared control terms act on the flip-flops: an asynchronous clear, a synchronous set and a test preload. The preload copies the levels applied at the output pins straight into the registers. Each pin shows its register through a per-cell polarity bit. The set and clear terms therefore fix the register, and the pin level that results depends on the polarity.

A small configuration store sits beside the cells. It holds the polarity bits and a lock bit. Once the lock is programmed, readback of the polarity bits returns the erased value (all ones), preload strobes are ignored and polarity writes have no effect. The only way to release the lock is a full erase. The erase also returns every polarity bit to its unprogrammed value of 1. A power-on reset input, held for some clocks, clears the registers and leaves the configuration store as it is.

Top module: `regcell_bank`

## Requirements
- R1: Each pin equals its register when that cell's polarity bit is 0, and the inverse of its register when the bit is 1.
- R2: While `rst` is high at a clock edge, every register becomes 0. The polarity bits and the lock are not changed by `rst`.
- R3: `clr_term` high forces every register to 0 at once, without waiting for a clock edge, and it overrides every other term.
- R4: With no reset and no accepted preload, `set_term` high at a clock edge sets every register to 1, whatever the sum terms are.
- R5: With no other term active, each register loads its `sum_in` bit at a clock edge.
- R6: With the lock clear, `pl_strobe` high at a clock edge loads `pl_pins` into the registers. This overrides `set_term` and `sum_in`.
- R7: After a preload, the next edge with only the sum terms active clocks on normally from the loaded state.
- R8: With the lock clear, `cfg_wr` high writes `cfg_pol` into the polarity bits at the edge. When `cfg_lock` is also high, it sets the lock. While the lock is clear, `rd_pol` returns the polarity bits.
- R9: While the lock is set, `rd_pol` reads all ones, whatever the stored polarity.
- R10: While the lock is set, `pl_strobe` is ignored. The registers follow `set_term` or `sum_in` as if no strobe were present.
- R11: While the lock is set, `cfg_wr` changes neither the polarity bits nor the lock. `cfg_erase` at an edge clears the lock and sets every polarity bit to 1.
- R12: When `cfg_erase` and `cfg_wr` are high at the same edge, the erase wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for registers and configuration store |
| rst | input | 1 | Synchronous power-on reset of the registers, active high |
| clr_term | input | 1 | Asynchronous clear term for all registers |
| set_term | input | 1 | Synchronous set term for all registers |
| sum_in | input | NCELL | Sum-term (next-state) input, one bit per cell |
| pl_strobe | input | 1 | Preload strobe |
| pl_pins | input | NCELL | Pin levels applied during preload |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_pol | input | NCELL | Polarity bits to write (1 = inverted pin) |
| cfg_lock | input | 1 | Sets the lock when written together with `cfg_wr` |
| cfg_erase | input | 1 | Full erase: clears the lock, sets the polarity bits to 1 |
| pin_out | output | NCELL | Output pin levels |
| rd_pol | output | NCELL | Polarity readback, all ones while locked |

## Verification
The pins are first checked after reset, set and clear under mixed polarity patterns (0x0F, 0x33, erased). Holding one register state under two polarities tells a register fault apart from a polarity fault. Preload is tried with the set term and a sum term active at the same time, both before and after locking, which separates preload priority from the lock gate. A sum term on the next edge shows that clocking resumes from the loaded state. Readback is tried with writes under the lock and with an erase that coincides with a write. A seeded random run then mixes every term against a bench model, including the async clear and locks landing mid-stream.

// File: rtl/regcell_pkg.sv
package regcell_pkg;

    localparam int unsigned NCELL_DEFAULT = 8;

    // source selected for the register on the next clock edge
    typedef enum logic [1:0] {
        SRC_POR     = 2'd0,
        SRC_PRELOAD = 2'd1,
        SRC_PRESET  = 2'd2,
        SRC_SUM     = 2'd3
    } reg_src_e;

    typedef struct packed {
        logic wr;
        logic lock;
        logic erase;
    } cfg_cmd_t;

    // priority: power-on reset, accepted preload, preset, sum term
    function automatic reg_src_e pick_src(input logic por,
                                          input logic pl_ok,
                                          input logic preset);
        if (por)
            return SRC_POR;
        else if (pl_ok)
            return SRC_PRELOAD;
        else if (preset)
            return SRC_PRESET;
        else
            return SRC_SUM;
    endfunction

    // polarity bit 1 drives the inverted register value onto the pin
    function automatic logic pin_level(input logic q, input logic inv);
        return inv ? ~q : q;
    endfunction

endpackage

// File: rtl/regcell_cfg.sv
module regcell_cfg
    import regcell_pkg::*;
#(
    parameter int unsigned NCELL = NCELL_DEFAULT
) (
    input  logic             clk,
    input  cfg_cmd_t         cmd,
    input  logic [NCELL-1:0] wpol,
    output logic [NCELL-1:0] pol,
    output logic             sec,
    output logic [NCELL-1:0] rd_pol
);

    localparam logic [NCELL-1:0] ERASED = '1;

    always_ff @(posedge clk) begin
        if (cmd.erase) begin
            pol <= ERASED;
            sec <= 1'b0;
        end else if (cmd.wr && !sec) begin
            pol <= wpol;
            sec <= cmd.lock;
        end
    end

    assign rd_pol = sec ? ERASED : pol;

endmodule

// File: rtl/regcell_ff.sv
module regcell_ff
    import regcell_pkg::*;
(
    input  logic     clk,
    input  logic     clr,
    input  reg_src_e src,
    input  logic     d,
    input  logic     pin_d,
    output logic     q
);

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            q <= 1'b0;
        end else begin
            unique case (src)
                SRC_POR:     q <= 1'b0;
                SRC_PRELOAD: q <= pin_d;
                SRC_PRESET:  q <= 1'b1;
                default:     q <= d;
            endcase
        end
    end

endmodule

// File: rtl/regcell_bank.sv
module regcell_bank
    import regcell_pkg::*;
#(
    parameter int unsigned NCELL = NCELL_DEFAULT
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr_term,
    input  logic             set_term,
    input  logic [NCELL-1:0] sum_in,
    input  logic             pl_strobe,
    input  logic [NCELL-1:0] pl_pins,
    input  logic             cfg_wr,
    input  logic [NCELL-1:0] cfg_pol,
    input  logic             cfg_lock,
    input  logic             cfg_erase,
    output logic [NCELL-1:0] pin_out,
    output logic [NCELL-1:0] rd_pol
);

    cfg_cmd_t         cmd;
    logic [NCELL-1:0] pol_cfg;
    logic             sec_cfg;
    logic [NCELL-1:0] q_reg;
    reg_src_e         src;

    assign cmd = '{wr: cfg_wr, lock: cfg_lock, erase: cfg_erase};

    regcell_cfg #(.NCELL(NCELL)) u_cfg (
        .clk    (clk),
        .cmd    (cmd),
        .wpol   (cfg_pol),
        .pol    (pol_cfg),
        .sec    (sec_cfg),
        .rd_pol (rd_pol)
    );

    // lock gates the preload strobe before source selection
    assign src = pick_src(rst, pl_strobe && !sec_cfg, set_term);

    for (genvar i = 0; i < NCELL; i++) begin : g_cell
        regcell_ff u_ff (
            .clk   (clk),
            .clr   (clr_term),
            .src   (src),
            .d     (sum_in[i]),
            .pin_d (pl_pins[i]),
            .q     (q_reg[i])
        );
        assign pin_out[i] = pin_level(q_reg[i], pol_cfg[i]);
    end

endmodule

// File: rtl/regcell_bank_chk.sv
module regcell_bank_chk #(
    parameter int unsigned NCELL = 8
) (
    input logic             clk,
    input logic             rst,
    input logic             clr_term,
    input logic             set_term,
    input logic             pl_strobe,
    input logic             cfg_erase,
    input logic [NCELL-1:0] sum_in,
    input logic [NCELL-1:0] q,
    input logic [NCELL-1:0] pol,
    input logic             sec
);

    // R2: power-on reset clears every register on the next edge
    assert_por_clear_R2: assert property (@(posedge clk) disable iff (clr_term)
        rst |=> (q == '0));

    // R4: preset without preload sets every register
    assert_preset_ones_R4: assert property (@(posedge clk) disable iff (rst || clr_term)
        (set_term && !pl_strobe) |=> (q == '1));

    // R5: no terms active, registers follow the sum terms
    assert_sum_load_R5: assert property (@(posedge clk) disable iff (rst || clr_term)
        (!set_term && !pl_strobe) |=> (q == $past(sum_in)));

    // R10: locked preload strobe is ignored
    assert_locked_preload_R10: assert property (@(posedge clk) disable iff (rst || clr_term)
        (sec && pl_strobe && !set_term) |=> (q == $past(sum_in)));

    // R11: lock and polarity hold without erase
    assert_lock_hold_R11: assert property (@(posedge clk) disable iff (rst)
        (sec && !cfg_erase) |=> (sec && $stable(pol)));

    // R11: erase releases the lock and restores erased polarity
    assert_erase_R11: assert property (@(posedge clk) disable iff (rst)
        cfg_erase |=> (!sec && (pol == '1)));

endmodule

bind regcell_bank regcell_bank_chk #(.NCELL(NCELL)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .clr_term  (clr_term),
    .set_term  (set_term),
    .pl_strobe (pl_strobe),
    .cfg_erase (cfg_erase),
    .sum_in    (sum_in),
    .q         (q_reg),
    .pol       (pol_cfg),
    .sec       (sec_cfg)
);

// File: tb/regcell_bank_tb.sv
module regcell_bank_tb;

    localparam int unsigned N = 8;
    localparam logic [N-1:0] ONES = '1;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         clr_term = 1'b0;
    logic         set_term = 1'b0;
    logic [N-1:0] sum_in = '0;
    logic         pl_strobe = 1'b0;
    logic [N-1:0] pl_pins = '0;
    logic         cfg_wr = 1'b0;
    logic [N-1:0] cfg_pol = '0;
    logic         cfg_lock = 1'b0;
    logic         cfg_erase = 1'b0;
    logic [N-1:0] pin_out;
    logic [N-1:0] rd_pol;

    int n_run = 0;
    int n_fail = 0;

    // bench model
    logic [N-1:0] m_q = '0;
    logic [N-1:0] m_pol = '1;
    logic         m_sec = 1'b0;

    always #5 clk = ~clk;

    regcell_bank #(.NCELL(N)) u_dut (
        .clk(clk), .rst(rst), .clr_term(clr_term), .set_term(set_term),
        .sum_in(sum_in), .pl_strobe(pl_strobe), .pl_pins(pl_pins),
        .cfg_wr(cfg_wr), .cfg_pol(cfg_pol), .cfg_lock(cfg_lock),
        .cfg_erase(cfg_erase), .pin_out(pin_out), .rd_pol(rd_pol)
    );

    function automatic logic [N-1:0] exp_pins(input logic [N-1:0] q, input logic [N-1:0] inv);
        return q ^ inv;
    endfunction

    function automatic logic [N-1:0] exp_rd(input logic [N-1:0] p, input logic s);
        return s ? ONES : p;
    endfunction

    task automatic chk(input logic ok, input string tag,
                       input logic [N-1:0] act, input logic [N-1:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic check_outputs(input string tag);
        logic [N-1:0] ep;
        logic [N-1:0] er;
        ep = exp_pins(m_q, m_pol);
        er = exp_rd(m_pol, m_sec);
        chk(pin_out === ep, {tag, " R1 pins"}, pin_out, ep);
        chk(rd_pol === er, {tag, (m_sec ? " R9 readback" : " R8 readback")}, rd_pol, er);
    endtask

    // drive at negedge, one clock edge, model update, check at negedge
    task automatic cycle(input logic r, input logic clr, input logic set,
                         input logic [N-1:0] d, input logic pl, input logic [N-1:0] pins,
                         input logic wr, input logic [N-1:0] wp, input logic lk,
                         input logic er, input string tag);
        rst = r; clr_term = clr; set_term = set; sum_in = d;
        pl_strobe = pl; pl_pins = pins; cfg_wr = wr; cfg_pol = wp;
        cfg_lock = lk; cfg_erase = er;
        @(posedge clk);
        if (clr)                m_q = '0;
        else if (r)             m_q = '0;
        else if (pl && !m_sec)  m_q = pins;
        else if (set)           m_q = ONES;
        else                    m_q = d;
        if (er) begin
            m_pol = ONES; m_sec = 1'b0;
        end else if (wr && !m_sec) begin
            m_pol = wp; m_sec = lk;
        end
        @(negedge clk);
        check_outputs(tag);
    endtask

    task automatic idle(input logic [N-1:0] d, input string tag);
        cycle(0, 0, 0, d, 0, '0, 0, '0, 0, 0, tag);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired actual=%h expected=%h", 1, 0);
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin : main
        int unsigned seed;
        seed = $urandom(32'd4242);
        @(negedge clk);
        // R2: power-on reset held with an erase to define the store
        for (int k = 0; k < 4; k++)
            cycle(1, 0, 0, '0, 0, '0, 0, '0, 0, 1, "R2 por");
        chk(pin_out === ONES, "R2 pins after por, erased polarity", pin_out, ONES);

        // R8 + R1: program mixed polarity
        cycle(0, 0, 0, '0, 0, '0, 1, 8'h0F, 0, 0, "R8 write");
        chk(rd_pol === 8'h0F, "R8 readback of written polarity", rd_pol, 8'h0F);
        chk(pin_out === 8'h0F, "R1 pins of cleared regs under pol 0F", pin_out, 8'h0F);

        // R4: preset beats sum terms
        cycle(0, 0, 1, 8'h00, 0, '0, 0, '0, 0, 0, "R4 preset");
        chk(pin_out === 8'hF0, "R1 R4 pins of set regs under pol 0F", pin_out, 8'hF0);

        // R2: rst leaves polarity intact
        cycle(1, 0, 0, 8'hFF, 0, '0, 0, '0, 0, 0, "R2 rst keeps cfg");
        chk(rd_pol === 8'h0F, "R2 polarity kept through rst", rd_pol, 8'h0F);

        // R3: async clear without an edge
        idle(8'hFF, "R5 load");
        clr_term = 1'b1;
        #1;
        chk(pin_out === 8'h0F, "R3 async clear before edge", pin_out, 8'h0F);
        cycle(0, 1, 1, 8'hFF, 1, 8'hAA, 0, '0, 0, 0, "R3 clear overrides");
        clr_term = 1'b0;

        // R6 + R7: preload with set and sum also active, then resume
        cycle(0, 0, 1, 8'h00, 1, 8'hA5, 0, '0, 0, 0, "R6 preload");
        chk(pin_out === (8'hA5 ^ 8'h0F), "R6 preload loaded pin data", pin_out, 8'hA5 ^ 8'h0F);
        idle(8'h3C, "R7 resume");
        chk(pin_out === (8'h3C ^ 8'h0F), "R7 clocking from preloaded state", pin_out, 8'h3C ^ 8'h0F);

        // lock with polarity 33
        cycle(0, 0, 0, 8'h00, 0, '0, 1, 8'h33, 1, 0, "R8 lock");
        chk(rd_pol === ONES, "R9 masked readback", rd_pol, ONES);
        // R11: write under lock ignored, observed through pins
        cycle(0, 0, 0, 8'h00, 0, '0, 1, 8'h00, 0, 0, "R11 locked write");
        chk(pin_out === 8'h33, "R11 polarity unchanged under lock", pin_out, 8'h33);
        // R10: preload ignored under lock
        cycle(0, 0, 0, 8'h11, 1, 8'hA5, 0, '0, 0, 0, "R10 locked preload");
        chk(pin_out === (8'h11 ^ 8'h33), "R10 preload blocked", pin_out, 8'h11 ^ 8'h33);

        // R12: erase beats a simultaneous write
        cycle(0, 0, 0, 8'h00, 0, '0, 1, 8'h55, 1, 1, "R12 erase+write");
        chk(rd_pol === ONES, "R12 erase wins readback", rd_pol, ONES);
        cycle(0, 0, 0, 8'h00, 0, '0, 1, 8'h55, 0, 0, "R11 unlocked write");
        chk(rd_pol === 8'h55, "R11 lock released by erase", rd_pol, 8'h55);

        // constrained random mix
        for (int k = 0; k < 600; k++) begin
            logic clr, set, pl, wr, lk, er;
            clr = ($urandom % 32) == 0;
            set = ($urandom % 8) == 0;
            pl  = ($urandom % 4) == 0;
            wr  = ($urandom % 12) == 0;
            lk  = wr && (($urandom % 4) == 0);
            er  = ($urandom % 60) == 0;
            cycle(($urandom % 50) == 0, clr, set, N'($urandom), pl, N'($urandom),
                  wr, N'($urandom), lk, er, "R5 R6 R10 random");
        end
        clr_term = 1'b0;

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule